// File: doc/BRIEF.md
# Cross-Warp Dual-Issue Scheduler

This block chooses up to two instructions per cycle from a pool of resident warps. Each warp shows a ready flag and a 2-bit code for the execution unit class its next instruction needs. Slot 0 is chosen by round-robin over the eligible warps. Slot 1, when it is used, takes a different warp whose instruction targets a different unit class. The two instructions always come from different warps, so no register hazard check is needed between them. They also never compete for the same unit.

The grants are combinational from the current inputs and the stored state. At each clock edge the block advances its round-robin pointer past the slot 0 warp. It also marks both granted warps as taken. A taken warp stays out of the selection until its ready flag has dropped and then risen again. The surrounding pipeline signals a new instruction this way.

Top module: `dual_issue_sched`

## Requirements
- R1: While rst_ni is low, both slot valid outputs are 0. After reset the round-robin search starts at warp 0, and no warp is marked taken.
- R2: Slot 0 grants the first eligible warp, where eligible means ready and not taken. The search runs in ascending order from the pointer and wraps from the highest warp to warp 0. After each slot 0 grant the pointer becomes that warp's index plus one, wrapping to 0.
- R3: When both slots are valid, their warp IDs differ.
- R4: Slot 1 grants the first eligible warp, other than the slot 0 warp, whose class code differs from the slot 0 class. The search starts at the slot 0 warp plus one and wraps.
- R5: When every eligible warp has the same class code as the slot 0 warp, only slot 0 is valid.
- R6: When no warp is eligible, neither slot is valid.
- R7: A warp granted in either slot is not granted again until its ready bit has been low for at least one cycle and then high again.
- R8: Each slot's class output equals the class input of its granted warp. The class of warp w is cls_i[2w+1:2w], with 0 = FP32, 1 = FP16, 2 = integer and 3 = complex.
- R9: A slot 1 grant does not move the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 16 | Per-warp ready flag |
| cls_i | input | 32 | Per-warp unit class code, 2 bits per warp |
| s0_valid_o | output | 1 | Slot 0 issues this cycle |
| s0_warp_o | output | 4 | Slot 0 warp ID |
| s0_cls_o | output | 2 | Slot 0 unit class |
| s1_valid_o | output | 1 | Slot 1 issues this cycle |
| s1_warp_o | output | 4 | Slot 1 warp ID |
| s1_cls_o | output | 2 | Slot 1 unit class |

## Verification
Pattern 1 sets every warp ready with mixed classes. This shows the round-robin sweep and that pairs follow the pointer. Pattern 2 uses a pool with a single class, which must fall back to single issue. Pattern 3 is a sparse set where same-class warps sit between the slot 0 warp and the first usable partner. This separates a correct slot 1 search from one that takes the next warp in line. It also shows whether a slot 1 grant wrongly moves the pointer. Last come ready drop-and-reassert sequences, wrap-around cases at both ends of the warp range, and a reset in mid-run. These check the taken marks and the restart at warp 0.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int unsigned CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    UC_FP32 = 2'd0,
    UC_FP16 = 2'd1,
    UC_INT  = 2'd2,
    UC_CPLX = 2'd3
  } unit_cls_e;
endpackage

// File: rtl/rr_pick.sv
// First set bit of req_i at or after start_i, wrapping.
module rr_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] start_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < int'(N); i++) begin
      int j;
      j = int'(start_i) + i;
      if (j >= int'(N)) j = j - int'(N);
      if (!found_o && req_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/taken_track.sv
// A warp is taken once granted; the mark clears when its ready bit drops.
module taken_track #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  ready_i,
  input  logic          g0_v_i,
  input  logic [IW-1:0] g0_idx_i,
  input  logic          g1_v_i,
  input  logic [IW-1:0] g1_idx_i,
  output logic [N-1:0]  elig_o
);
  logic [N-1:0] taken_q, taken_d;

  always_comb begin
    for (int w = 0; w < int'(N); w++) begin
      if (!ready_i[w])
        taken_d[w] = 1'b0;
      else if ((g0_v_i && g0_idx_i == IW'(w)) || (g1_v_i && g1_idx_i == IW'(w)))
        taken_d[w] = 1'b1;
      else
        taken_d[w] = taken_q[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taken_q <= '0;
    else         taken_q <= taken_d;
  end

  assign elig_o = ready_i & ~taken_q;

  // R7: a taken warp that stays ready is never eligible
  a_r7_taken_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g0_v_i && ready_i[g0_idx_i]) |=> (!ready_i[$past(g0_idx_i)] || !elig_o[$past(g0_idx_i)]));
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import dis_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_WARPS-1:0]       ready_i,
  input  logic [NUM_WARPS*CLS_W-1:0] cls_i,
  output logic                       s0_valid_o,
  output logic [$clog2(NUM_WARPS)-1:0] s0_warp_o,
  output logic [CLS_W-1:0]           s0_cls_o,
  output logic                       s1_valid_o,
  output logic [$clog2(NUM_WARPS)-1:0] s1_warp_o,
  output logic [CLS_W-1:0]           s1_cls_o
);
  localparam int unsigned IW = $clog2(NUM_WARPS);
  localparam logic [IW-1:0] LAST = IW'(NUM_WARPS - 1);

  logic [CLS_W-1:0]     cls_w [NUM_WARPS];
  logic [NUM_WARPS-1:0] elig, req1;
  logic [IW-1:0]        ptr_q, idx0, idx1, start1;
  logic                 found0, found1, v0, v1;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_unpack
    assign cls_w[w] = cls_i[w*CLS_W +: CLS_W];
  end

  taken_track #(.N(NUM_WARPS), .IW(IW)) u_taken (
    .clk_i, .rst_ni, .ready_i,
    .g0_v_i(v0), .g0_idx_i(idx0),
    .g1_v_i(v1), .g1_idx_i(idx1),
    .elig_o(elig)
  );

  rr_pick #(.N(NUM_WARPS), .IW(IW)) u_pick0 (
    .req_i(elig), .start_i(ptr_q), .found_o(found0), .idx_o(idx0)
  );

  always_comb begin
    for (int w = 0; w < int'(NUM_WARPS); w++)
      req1[w] = elig[w] && (cls_w[w] != cls_w[idx0]) && (IW'(w) != idx0);
  end

  assign start1 = (idx0 == LAST) ? '0 : idx0 + 1'b1;

  rr_pick #(.N(NUM_WARPS), .IW(IW)) u_pick1 (
    .req_i(req1), .start_i(start1), .found_o(found1), .idx_o(idx1)
  );

  assign v0 = rst_ni && found0;
  assign v1 = v0 && found1;

  // pointer follows slot 0 only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (v0)  ptr_q <= start1;
  end

  assign s0_valid_o = v0;
  assign s0_warp_o  = idx0;
  assign s0_cls_o   = cls_w[idx0];
  assign s1_valid_o = v1;
  assign s1_warp_o  = idx1;
  assign s1_cls_o   = cls_w[idx1];

  a_r2_slot0_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s0_valid_o |-> ready_i[s0_warp_o]);
  a_r3_distinct_warp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_valid_o && s1_valid_o) |-> (s0_warp_o != s1_warp_o));
  a_r4_distinct_cls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_valid_o && s1_valid_o) |-> (s0_cls_o != s1_cls_o));
  a_r4_slot1_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_o |-> ready_i[s1_warp_o]);
  a_r7_no_regrant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s0_valid_o |=> !(s0_valid_o && s0_warp_o == $past(s0_warp_o))
                && !(s1_valid_o && s1_warp_o == $past(s0_warp_o)));
endmodule

// File: tb/sim_dual_issue_sched.sv
`timescale 1ns/1ps
module sim_dual_issue_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ready_i = '0;
  logic [31:0] cls_i;
  logic [1:0]  c [16];
  logic        s0_valid_o, s1_valid_o;
  logic [3:0]  s0_warp_o, s1_warp_o;
  logic [1:0]  s0_cls_o, s1_cls_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  always_comb
    for (int w = 0; w < 16; w++) cls_i[2*w +: 2] = c[w];

  dual_issue_sched u0 (.*);

  task automatic chk(string req, bit v0, int w0, int c0, bit v1, int w1, int c1);
    bit ok;
    n_chk++;
    ok = (s0_valid_o == v0) && (s1_valid_o == v1);
    if (v0) ok = ok && (s0_warp_o == w0[3:0]) && (s0_cls_o == c0[1:0]);
    if (v1) ok = ok && (s1_warp_o == w1[3:0]) && (s1_cls_o == c1[1:0]);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got s0=%b/%0d/%0d s1=%b/%0d/%0d exp s0=%b/%0d/%0d s1=%b/%0d/%0d",
               req, s0_valid_o, s0_warp_o, s0_cls_o, s1_valid_o, s1_warp_o, s1_cls_o,
               v0, w0, c0, v1, w1, c1);
    end
  endtask

  task automatic step(logic [15:0] rdy);
    @(negedge clk_i);
    ready_i = rdy;
    #1;
  endtask

  task automatic cls_mod4();
    for (int w = 0; w < 16; w++) c[w] = 2'(w % 4);
  endtask

  task automatic t_reset_sweep();
    cls_mod4();
    rst_ni = 1'b0;
    step(16'hFFFF);
    chk("R1 valids low in reset", 0, 0, 0, 0, 0, 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R1/R3/R4 start at warp0", 1, 0, 0, 1, 1, 1);
    step(16'hFFFF);
    chk("R2 rr advance", 1, 2, 2, 1, 3, 3);
    step(16'hFFFF);
    chk("R2/R3 rr advance", 1, 4, 0, 1, 5, 1);
    step(16'h0000);
    chk("R6 nothing ready", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_single_class();
    for (int w = 0; w < 16; w++) c[w] = 2'd1;
    step(16'hFFFF);
    chk("R5 one class single issue", 1, 5, 1, 0, 0, 0);
    step(16'hFFFF);
    chk("R5/R7 skip taken", 1, 6, 1, 0, 0, 0);
    step(16'h0000);
  endtask

  task automatic t_sparse_partner();
    cls_mod4();
    c[7] = 2'd2; c[8] = 2'd2; c[10] = 2'd0; c[11] = 2'd2;
    step(16'h0D80);
    chk("R4/R8 partner skips same class", 1, 7, 2, 1, 10, 0);
    step(16'h0D80);
    chk("R9 slot1 leaves pointer", 1, 8, 2, 0, 0, 0);
    step(16'h0D80);
    chk("R2 next after pointer", 1, 11, 2, 0, 0, 0);
    step(16'h0D80);
    chk("R7 all taken", 0, 0, 0, 0, 0, 0);
    step(16'h0980);
    chk("R7 ready low no grant", 0, 0, 0, 0, 0, 0);
    step(16'h0D80);
    chk("R7 regrant after reassert", 1, 10, 0, 0, 0, 0);
    step(16'h0000);
  endtask

  task automatic t_wrap();
    c[3] = 2'd3; c[12] = 2'd3;
    step(16'h1008);
    chk("R2/R5 search from pointer", 1, 12, 3, 0, 0, 0);
    step(16'h1008);
    chk("R2 wrap to low warp", 1, 3, 3, 0, 0, 0);
    step(16'h0000);
    c[14] = 2'd0; c[15] = 2'd0; c[1] = 2'd3;
    step(16'hC002);
    chk("R4 slot1 search wraps", 1, 14, 0, 1, 1, 3);
  endtask

  task automatic t_mid_reset();
    cls_mod4();
    @(negedge clk_i); rst_ni = 1'b0; ready_i = 16'hFFFF; #1;
    chk("R1 valids low in mid reset", 0, 0, 0, 0, 0, 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R1 pointer and marks cleared", 1, 0, 0, 1, 1, 1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_sweep();
    t_single_class();
    t_sparse_partner();
    t_wrap();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule